// File: doc/BRIEF.md
# Symmetric Tuple Canonicalizer

This block takes a work item made of four elements, arranged as two pairs (i, j | k, l), and rewrites it into one canonical order. Each element carries a 16-bit identifier and three 3-bit attributes, one per axis (x, y, z), each with a value from 0 to 7. Only three reorderings are allowed, in any combination: swapping the two elements of the first pair, swapping the two elements of the second pair, and exchanging the two pairs. Together they give eight equivalent forms of one item. The block picks one of those forms so that any two equivalent items leave with the same 36-bit attribute key. A later exact-match search can then group items by that key. The block only needs a canonical key, not a full sort of the four elements.

Items enter and leave on valid/ready streams. The block is a two-stage pipeline that accepts one item per clock.
- The first stage puts each pair in order, larger element first.
- The second stage decides whether the two pairs trade places.

Each result leaves as a 100-bit word that holds the reordered attribute key and, below it, the four identifiers in the same order. A stalled output holds both stages.

Top module: `tuple_canon`

## Requirements
- R1: The input attribute word is 36 bits, with element i in bits [35:27], j in [26:18], k in [17:9] and l in [8:0]. Inside each 9-bit element field, x occupies the top 3 bits, then y, then z at the bottom. The input identifier word is 64 bits, with i in [63:48] down to l in [15:0]. The output word is 100 bits and has the same layout: the four 9-bit keys, leading element first, in bits [99:64], then the four identifiers in the same element order in bits [63:0].
- R2: An element's sort key is its 9-bit field read as an unsigned number. In every output, within each pair, the first key is greater than or equal to the second.
- R3: The output pair with the larger leading key is placed first.
- R4: When the leading keys of the two pairs are equal, the pair with the larger trailing key is placed first.
- R5: Equal keys never cause a reordering. In particular, an item whose four keys are all equal leaves in its input order.
- R6: Each identifier stays with its own attribute field through every swap.
- R7: An item accepted at a clock edge, with no stall, appears on the output after the second following edge. With the output ready, one item is accepted every cycle.
- R8: While the output is valid and not ready, the output word and the valid signal hold steady. Every accepted item leaves exactly once and in order, with none dropped and none duplicated.
- R9: After reset the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can accept an item this cycle |
| in_ids | input | 64 | Four element identifiers, element i at the top |
| in_attr | input | 36 | Four 9-bit attribute triples, element i at the top |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_word | output | 100 | Canonical key in the upper 36 bits, identifiers in the lower 64 |

## Verification
The hardest cases to reach from the ports are ties:
- ties between leading keys, which decide the pair exchange through the trailing keys;
- equal keys inside a pair, which must leave the identifier order untouched.

Uniform random attributes almost never produce these ties. The stimulus therefore draws attribute values from a two-value range for part of the run and from the full 0..7 range for the rest, alongside directed items built around ties. Random output backpressure is applied while items stream in back to back. This forces stalls that arrive while both stages hold items, and the scoreboard then shows any loss, duplication or change in the held word.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned ID_W    = 16;
  localparam int unsigned AX_W    = 3;
  localparam int unsigned N_AX    = 3;
  localparam int unsigned N_EL    = 4;
  localparam int unsigned KEY_W   = AX_W * N_AX;
  localparam int unsigned ATTR_W  = KEY_W * N_EL;
  localparam int unsigned IDS_W   = ID_W * N_EL;
  localparam int unsigned WORD_W  = ATTR_W + IDS_W;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic [ID_W-1:0]  id;
  } elem_t;

  typedef elem_t [N_EL-1:0] quad_t;

  localparam int unsigned QUAD_W = $bits(quad_t);
endpackage

// File: rtl/tc_pair_sort.sv
module tc_pair_sort
  import tc_pkg::*;
(
  input  elem_t a,
  input  elem_t b,
  output elem_t hi,
  output elem_t lo
);
  logic swap;

  always_comb begin
    swap = (b.key > a.key);
    hi   = swap ? b : a;
    lo   = swap ? a : b;
  end
endmodule

// File: rtl/tc_pair_swap.sv
module tc_pair_swap
  import tc_pkg::*;
(
  input  quad_t q_in,
  output quad_t q_out
);
  logic [2*KEY_W-1:0] lead_pair;
  logic [2*KEY_W-1:0] tail_pair;
  logic               exch;

  always_comb begin
    lead_pair = {q_in[0].key, q_in[1].key};
    tail_pair = {q_in[2].key, q_in[3].key};
    exch      = (tail_pair > lead_pair);
    if (exch) begin
      q_out[0] = q_in[2];
      q_out[1] = q_in[3];
      q_out[2] = q_in[0];
      q_out[3] = q_in[1];
    end else begin
      q_out = q_in;
    end
  end
endmodule

// File: rtl/tc_pipe_en.sv
module tc_pipe_en #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         vout,
  output logic [W-1:0] dout
);
  logic         v_d, v_q;
  logic [W-1:0] d_d, d_q;
  logic         load;

  always_comb begin
    load = en && vin;
    v_d  = en ? vin : v_q;
    d_d  = load ? din : d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (load) d_q <= d_d;
  end

  assign vout = v_q;
  assign dout = d_q;
endmodule

// File: rtl/tuple_canon.sv
module tuple_canon
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDS_W-1:0]  in_ids,
  input  logic [ATTR_W-1:0] in_attr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  localparam int unsigned N_PAIR = N_EL / 2;

  quad_t in_q;
  quad_t s1_d, s1_q;
  quad_t s2_d, s2_q;
  logic  s1_v, s2_v;
  logic  adv;

  always_comb begin
    for (int e = 0; e < N_EL; e++) begin
      in_q[e].key = in_attr[ATTR_W-1-e*KEY_W -: KEY_W];
      in_q[e].id  = in_ids[IDS_W-1-e*ID_W -: ID_W];
    end
  end

  assign adv      = !s2_v || out_ready;
  assign in_ready = adv;

  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    tc_pair_sort u_sort (
      .a  (in_q[2*g]),
      .b  (in_q[2*g+1]),
      .hi (s1_d[2*g]),
      .lo (s1_d[2*g+1])
    );
  end

  tc_pipe_en #(.W(QUAD_W)) u_stage1 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .vin   (in_valid),
    .din   (s1_d),
    .vout  (s1_v),
    .dout  (s1_q)
  );

  tc_pair_swap u_swap (
    .q_in  (s1_q),
    .q_out (s2_d)
  );

  tc_pipe_en #(.W(QUAD_W)) u_stage2 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .vin   (s1_v),
    .din   (s2_d),
    .vout  (s2_v),
    .dout  (s2_q)
  );

  always_comb begin
    for (int e = 0; e < N_EL; e++) begin
      out_word[WORD_W-1-e*KEY_W -: KEY_W] = s2_q[e].key;
      out_word[IDS_W-1-e*ID_W -: ID_W]    = s2_q[e].id;
    end
  end

  assign out_valid = s2_v;
endmodule

// File: rtl/tuple_canon_chk.sv
module tuple_canon_chk
  import tc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);
  logic [KEY_W-1:0] k0, k1, k2, k3;

  assign k0 = out_word[WORD_W-1 -: KEY_W];
  assign k1 = out_word[WORD_W-1-KEY_W -: KEY_W];
  assign k2 = out_word[WORD_W-1-2*KEY_W -: KEY_W];
  assign k3 = out_word[WORD_W-1-3*KEY_W -: KEY_W];

  AST_PAIR_INNER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (k0 >= k1) && (k2 >= k3)); // R2

  AST_PAIR_LEX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({k0, k1} >= {k2, k3})); // R3

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R8

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid); // R7
endmodule

bind tuple_canon tuple_canon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/tuple_canon_bench.sv
`timescale 1ns/1ps
module tuple_canon_bench;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [63:0]  in_ids;
  logic [35:0]  in_attr;
  logic         out_valid;
  logic         out_ready;
  logic [99:0]  out_word;

  int           n_checks;
  int           n_fail;
  bit           bp_on;
  bit           done;
  logic [99:0]  exp_q[$];
  string        tag_q[$];
  bit           prev_stall;
  logic [99:0]  prev_word;

  tuple_canon u_tuple_canon (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_ids    (in_ids),
    .in_attr   (in_attr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(bit ok, string req, string what, logic [99:0] act, logic [99:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Canonical form: the largest 36-bit key over the eight allowed forms; among
  // equal keys the form with the fewest swaps, in the order listed, wins.
  function automatic logic [99:0] ref_canon(logic [63:0] ids, logic [35:0] attr);
    logic [8:0]  k [4];
    logic [15:0] d [4];
    int          ord [4];
    logic [35:0] cand, best_key;
    logic [63:0] best_ids;
    bit          found;
    found    = 1'b0;
    best_key = '0;
    best_ids = '0;
    for (int e = 0; e < 4; e++) begin
      k[e] = attr[35-9*e -: 9];
      d[e] = ids[63-16*e -: 16];
    end
    for (int p = 0; p < 8; p++) begin
      int a0, a1, b0, b1;
      a0 = (p & 1) ? 1 : 0;
      a1 = (p & 1) ? 0 : 1;
      b0 = (p & 2) ? 3 : 2;
      b1 = (p & 2) ? 2 : 3;
      if (p & 4) begin
        ord[0] = b0; ord[1] = b1; ord[2] = a0; ord[3] = a1;
      end else begin
        ord[0] = a0; ord[1] = a1; ord[2] = b0; ord[3] = b1;
      end
      cand = {k[ord[0]], k[ord[1]], k[ord[2]], k[ord[3]]};
      if (!found || cand > best_key) begin
        found    = 1'b1;
        best_key = cand;
        best_ids = {d[ord[0]], d[ord[1]], d[ord[2]], d[ord[3]]};
      end
    end
    return {best_key, best_ids};
  endfunction

  task automatic send(logic [63:0] ids, logic [35:0] attr, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_ids   = ids;
    in_attr  = attr;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(ref_canon(ids, attr));
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [35:0] pack4(logic [8:0] a, logic [8:0] b, logic [8:0] c, logic [8:0] e);
    return {a, b, c, e};
  endfunction

  function automatic logic [8:0] rnd_key(bit narrow);
    logic [8:0] r;
    for (int ax = 0; ax < 3; ax++)
      r[ax*3 +: 3] = narrow ? 3'($urandom % 2) : 3'($urandom % 8);
    return r;
  endfunction

  // output backpressure
  always @(negedge clk) out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && (out_word == prev_word), "R8", "held word after stall",
              out_word, prev_word);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "output with nothing expected", out_word, '0);
        end else begin
          logic [99:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word == e, t, "canonical word", out_word, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_word  = out_word;
    end else begin
      prev_stall = 1'b0;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R7", "watchdog expired", '0, '0);
      finish_run();
    end
  end

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    bp_on      = 1'b0;
    done       = 1'b0;
    prev_stall = 1'b0;
    prev_word  = '0;
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_ids     = '0;
    in_attr    = '0;
    out_ready  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R9", "out_valid in reset", 100'(out_valid), 100'd0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", 100'(in_ready), 100'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R9", "out_valid after reset", 100'(out_valid), 100'd0);

    // R1: field layout, written out by hand
    send(64'hAAAA_0001_0002_0003, pack4(9'o701, 9'o000, 9'o000, 9'o000), "R1");
    idle();
    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "R1", "layout item drained", 100'(exp_q.size()), 100'd0);
    begin
      logic [99:0] hand;
      hand = {36'o701000000000, 64'hAAAA_0001_0002_0003};
      check(ref_canon(64'hAAAA_0001_0002_0003, pack4(9'o701, 0, 0, 0)) == hand, "R1",
            "hand layout", ref_canon(64'hAAAA_0001_0002_0003, pack4(9'o701, 0, 0, 0)), hand);
    end

    // R7: latency of one item through an empty pipe
    @(negedge clk);
    in_valid = 1'b1;
    in_ids   = 64'h1111_2222_3333_4444;
    in_attr  = pack4(9'd3, 9'd9, 9'd1, 9'd2);
    exp_q.push_back(ref_canon(in_ids, in_attr));
    tag_q.push_back("R7");
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R7", "not valid one edge after accept", 100'(out_valid), 100'd0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R7", "valid two edges after accept", 100'(out_valid), 100'd1);
    repeat (2) @(posedge clk);

    // directed orderings
    send(64'h0A0A_0B0B_0C0C_0D0D, pack4(9'd1, 9'd6, 9'd0, 9'd0), "R2");
    send(64'h0A0A_0B0B_0C0C_0D0D, pack4(9'd1, 9'd0, 9'd4, 9'd2), "R3");
    send(64'h0A0A_0B0B_0C0C_0D0D, pack4(9'd5, 9'd1, 9'd5, 9'd3), "R4");
    send(64'h0A0A_0B0B_0C0C_0D0D, pack4(9'd4, 9'd4, 9'd4, 9'd4), "R5");
    send(64'h0A0A_0B0B_0C0C_0D0D, pack4(9'd5, 9'd5, 9'd3, 9'd7), "R5");
    send(64'hBEEF_CAFE_F00D_D00D, pack4(9'o123, 9'o321, 9'o777, 9'o000), "R6");
    idle();
    repeat (4) @(posedge clk);

    // R7: back-to-back stream, ready never drops
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_ids   = {$urandom, $urandom};
      in_attr  = pack4(rnd_key(n[0]), rnd_key(1'b1), rnd_key(n[1]), rnd_key(1'b0));
      #1;
      check(in_ready == 1'b1, "R7", "ready during stream", 100'(in_ready), 100'd1);
      exp_q.push_back(ref_canon(in_ids, in_attr));
      tag_q.push_back("R6");
      @(posedge clk);
    end
    idle();
    repeat (4) @(posedge clk);

    // R8: random backpressure with tie-heavy and full-range keys
    bp_on = 1'b1;
    for (int n = 0; n < 400; n++) begin
      bit nar;
      nar = (n < 200);
      send({$urandom, $urandom},
           pack4(rnd_key(nar), rnd_key(nar), rnd_key(nar), rnd_key(nar)),
           nar ? "R4" : "R8");
    end
    idle();
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    check(exp_q.size() == 0, "R8", "all items delivered once", 100'(exp_q.size()), 100'd0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "no extra output", 100'(out_valid), 100'd0);

    done = 1'b1;
    finish_run();
  end
endmodule